// File: doc/BRIEF.md
# Two-Port ASCII Command Line Decoder

The decoder takes received bytes from two serial ports and turns each carriage-return-terminated text line into a decoded command. A line starts with a two-letter code in either case. A question mark may follow the code, or a string of decimal digits may follow it. The decoder reports which command arrived and whether it is a query. For the frequency command it also reports the sub-command letter. It reports the value of the decimal parameter and the port the line came from, so that a response can be routed back to that port.

Both ports share one parser. An arbiter locks onto a port when the first byte of a line from that port is accepted, and holds that lock until the terminator. The other port is held off through its ready signal. Only one byte is consumed per clock, and each byte is decoded within the cycle it is accepted. Lines that are malformed, too short, too long or of unknown code raise a one-cycle error strobe and do not produce a result.

Top module: `cmd_decoder`

## Requirements
- R1: A line is the sequence of bytes accepted from one port up to and including carriage return 0x0D. When the CR of a well-formed line is accepted on a clock edge, done_o is high for exactly the one cycle after that edge.
- R2: Letters a-z are folded to A-Z before the code is decoded, so lower-case and upper-case spellings give the same result.
- R3: cmd_id_o encodes the two-letter code as follows: PD=1, PW=2, RC=3, RR=4, RS=5, ST=6, SQ=7, VU=8. Any code whose first letter is F is the frequency command, id 9.
- R4: For the frequency command, sub_o encodes the second character as R=1, T=2, S=3, U=4, D=5, ?=6. For every other command sub_o is 0. An F followed by any other character is an unknown code.
- R5: query_o is 1 when the third character of the line is '?' (0x3F), or when the line is the frequency command with '?' as its second character.
- R6: The characters from the third onward form the parameter. A '?' in the third position is excluded. Each digit updates the value as value*10+digit, modulo 2^32. The value starts from 0 on every line.
- R7: param_err_o is reported together with done_o. It is 1 when any parameter character is not a digit '0'..'9'.
- R8: err_o pulses for one cycle in place of done_o when the line has fewer than 2 characters before CR, more than 16 characters before CR, or an unknown code. All result outputs keep their previous values in that case.
- R9: port_o gives the tag of the port that delivered the line. Port index 0 has tag 1 and port index 1 has tag 2.
- R10: Once a non-CR byte from a port is accepted, every other port's ready_o stays low until that port's CR is accepted. When no line is open, the lowest-index port with valid high is the one served.
- R11: After reset, done_o, err_o and all result outputs are 0. The result outputs change only in a cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | NUM_PORTS | Received byte valid, one bit per port |
| rx_data_i | input | 8*NUM_PORTS | Received bytes, port i in bits [8i+7:8i] |
| rx_ready_o | output | NUM_PORTS | Byte accepted when valid and ready are both high |
| done_o | output | 1 | One-cycle strobe: a decoded result is present |
| err_o | output | 1 | One-cycle strobe: the line was discarded |
| cmd_id_o | output | 4 | Decoded command identifier |
| query_o | output | 1 | The command is a query |
| sub_o | output | 3 | Frequency sub-command code |
| param_o | output | 32 | Accumulated decimal parameter |
| param_err_o | output | 1 | The parameter held a non-digit |
| port_o | output | 2 | Tag of the source port |

## Verification
Every known code is sent in upper and lower case. This separates case folding from the table lookup. Frequency lines cover each sub-letter, with both nine-digit and six-digit parameters, and they are contrasted with ordinary codes followed by '?' or by digits. That contrast shows that the query flag, the sub-code and the parameter field are each taken from the right character position. Malformed lines are also sent: an empty line, a single letter, an unknown pair, an F with a bad sub-letter, a line of exactly 16 characters and one of 17, and a parameter with a letter in it. These lines separate the discard paths from the param_err path, and they mark the length boundary. Lines are also offered on both ports at once, in both start orders. This shows that the arbiter's priority and its lock work as required, and that the reported tag follows the line.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_Q  = 8'h3F;
  localparam logic [7:0] CH_F  = 8'h46;

  typedef enum logic [3:0] {
    CMD_NONE = 4'd0, CMD_PD = 4'd1, CMD_PW = 4'd2, CMD_RC = 4'd3,
    CMD_RR = 4'd4, CMD_RS = 4'd5, CMD_ST = 4'd6, CMD_SQ = 4'd7,
    CMD_VU = 4'd8, CMD_FREQ = 4'd9
  } cmd_id_e;

  typedef enum logic [2:0] {
    SUB_NONE = 3'd0, SUB_RX = 3'd1, SUB_TX = 3'd2, SUB_SIMPLEX = 3'd3,
    SUB_UP = 3'd4, SUB_DOWN = 3'd5, SUB_QUERY = 3'd6
  } sub_e;

  function automatic cmd_id_e code_lookup(logic [7:0] a, logic [7:0] b);
    case ({a, b})
      "PD":    return CMD_PD;
      "PW":    return CMD_PW;
      "RC":    return CMD_RC;
      "RR":    return CMD_RR;
      "RS":    return CMD_RS;
      "ST":    return CMD_ST;
      "SQ":    return CMD_SQ;
      "VU":    return CMD_VU;
      default: return CMD_NONE;
    endcase
  endfunction

  function automatic sub_e freq_sub(logic [7:0] b);
    case (b)
      "R":     return SUB_RX;
      "T":     return SUB_TX;
      "S":     return SUB_SIMPLEX;
      "U":     return SUB_UP;
      "D":     return SUB_DOWN;
      CH_Q:    return SUB_QUERY;
      default: return SUB_NONE;
    endcase
  endfunction
endpackage

// File: rtl/cmd_char_class.sv
module cmd_char_class
  import cmd_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic [7:0] upper_o,
  output logic       is_cr_o,
  output logic       is_q_o,
  output logic       is_digit_o,
  output logic [3:0] digit_o
);
  always_comb begin
    upper_o    = (byte_i >= "a" && byte_i <= "z") ? byte_i - 8'h20 : byte_i;
    is_cr_o    = byte_i == CH_CR;
    is_q_o     = byte_i == CH_Q;
    is_digit_o = byte_i >= "0" && byte_i <= "9";
    digit_o    = byte_i[3:0];
  end
endmodule

// File: rtl/cmd_port_arb.sv
module cmd_port_arb
  import cmd_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int TAG_W     = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_PORTS-1:0]   valid_i,
  input  logic [NUM_PORTS*8-1:0] data_i,
  output logic [NUM_PORTS-1:0]   ready_o,
  output logic                   byte_valid_o,
  output logic [7:0]             byte_o,
  output logic [TAG_W-1:0]       tag_o
);
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic                 lock_q;
  logic [IDX_W-1:0]     owner_q;
  logic [IDX_W-1:0]     sel;
  logic [NUM_PORTS-1:0] lower_busy;
  logic [NUM_PORTS-1:0] grant;

  always_comb begin
    logic busy;
    busy = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      lower_busy[i] = busy;
      busy = busy | valid_i[i];
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_ready
    assign ready_o[g] = lock_q ? (owner_q == IDX_W'(g)) : !lower_busy[g];
  end

  assign grant        = valid_i & ready_o;
  assign byte_valid_o = |grant;

  always_comb begin
    sel    = '0;
    byte_o = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (grant[i]) begin
        sel    = IDX_W'(i);
        byte_o = data_i[i*8 +: 8];
      end
    end
  end

  assign tag_o = TAG_W'(sel) + TAG_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
    end else if (byte_valid_o) begin
      if (byte_o == CH_CR) begin
        lock_q <= 1'b0;
      end else begin
        lock_q  <= 1'b1;
        owner_q <= sel;
      end
    end
  end
endmodule

// File: rtl/cmd_line_parser.sv
module cmd_line_parser
  import cmd_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int TAG_W   = 2,
  parameter int VAL_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             done_o,
  output logic             err_o,
  output logic [3:0]       cmd_id_o,
  output logic             query_o,
  output logic [2:0]       sub_o,
  output logic [VAL_W-1:0] param_o,
  output logic             param_err_o,
  output logic [TAG_W-1:0] port_o
);
  localparam int LEN_W = $clog2(MAX_LEN + 2);
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MAX_LEN + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

  logic [7:0]       upper;
  logic             is_cr, is_q, is_digit;
  logic [3:0]       digit;

  cmd_char_class u_class (
    .byte_i    (byte_i),
    .upper_o   (upper),
    .is_cr_o   (is_cr),
    .is_q_o    (is_q),
    .is_digit_o(is_digit),
    .digit_o   (digit)
  );

  logic [LEN_W-1:0] len_q;
  logic [7:0]       c0_q, c1_q;
  logic             qry_q, perr_q;
  logic [VAL_W-1:0] val_q;

  logic [LEN_W-1:0] len_inc;
  logic             is_freq, bad, qry_n;
  sub_e             sub_n;
  cmd_id_e          id_n;
  logic [VAL_W-1:0] val_n;

  always_comb begin
    len_inc = (len_q == LEN_SAT) ? len_q : len_q + LEN_W'(1);
    is_freq = c0_q == CH_F;
    sub_n   = is_freq ? freq_sub(c1_q) : SUB_NONE;
    if (is_freq) id_n = (sub_n != SUB_NONE) ? CMD_FREQ : CMD_NONE;
    else         id_n = code_lookup(c0_q, c1_q);
    bad     = (len_q < LEN_W'(2)) || (len_q > LEN_MAX) || (id_n == CMD_NONE);
    qry_n   = qry_q || (is_freq && c1_q == CH_Q);
    val_n   = (val_q << 3) + (val_q << 1) + VAL_W'(digit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q       <= '0;
      c0_q        <= '0;
      c1_q        <= '0;
      qry_q       <= 1'b0;
      perr_q      <= 1'b0;
      val_q       <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      cmd_id_o    <= '0;
      query_o     <= 1'b0;
      sub_o       <= '0;
      param_o     <= '0;
      param_err_o <= 1'b0;
      port_o      <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (byte_valid_i) begin
        if (is_cr) begin
          if (bad) begin
            err_o <= 1'b1;
          end else begin
            done_o      <= 1'b1;
            cmd_id_o    <= id_n;
            sub_o       <= sub_n;
            query_o     <= qry_n;
            param_o     <= val_q;
            param_err_o <= perr_q;
            port_o      <= tag_i;
          end
          len_q  <= '0;
          c0_q   <= '0;
          c1_q   <= '0;
          qry_q  <= 1'b0;
          perr_q <= 1'b0;
          val_q  <= '0;
        end else begin
          len_q <= len_inc;
          if (len_q == '0)                         c0_q  <= upper;
          else if (len_q == LEN_W'(1))             c1_q  <= upper;
          else if (len_q == LEN_W'(2) && is_q)     qry_q <= 1'b1;
          else if (is_digit)                       val_q <= val_n;
          else                                     perr_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder #(
  parameter int NUM_PORTS = 2,
  parameter int MAX_LEN   = 16,
  parameter int VAL_W     = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_PORTS-1:0]             rx_valid_i,
  input  logic [NUM_PORTS*8-1:0]           rx_data_i,
  output logic [NUM_PORTS-1:0]             rx_ready_o,
  output logic                             done_o,
  output logic                             err_o,
  output logic [3:0]                       cmd_id_o,
  output logic                             query_o,
  output logic [2:0]                       sub_o,
  output logic [VAL_W-1:0]                 param_o,
  output logic                             param_err_o,
  output logic [$clog2(NUM_PORTS+1)-1:0]   port_o
);
  localparam int TAG_W = $clog2(NUM_PORTS + 1);

  logic             byte_valid;
  logic [7:0]       byte_d;
  logic [TAG_W-1:0] tag;

  cmd_port_arb #(.NUM_PORTS(NUM_PORTS), .TAG_W(TAG_W)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (rx_valid_i),
    .data_i      (rx_data_i),
    .ready_o     (rx_ready_o),
    .byte_valid_o(byte_valid),
    .byte_o      (byte_d),
    .tag_o       (tag)
  );

  cmd_line_parser #(.MAX_LEN(MAX_LEN), .TAG_W(TAG_W), .VAL_W(VAL_W)) u_parse (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_valid_i(byte_valid),
    .byte_i      (byte_d),
    .tag_i       (tag),
    .done_o      (done_o),
    .err_o       (err_o),
    .cmd_id_o    (cmd_id_o),
    .query_o     (query_o),
    .sub_o       (sub_o),
    .param_o     (param_o),
    .param_err_o (param_err_o),
    .port_o      (port_o)
  );
endmodule

// File: rtl/cmd_decoder_chk.sv
module cmd_decoder_chk #(
  parameter int NUM_PORTS = 2,
  parameter int VAL_W     = 32
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_PORTS-1:0]           rx_valid_i,
  input logic [NUM_PORTS-1:0]           rx_ready_o,
  input logic                           done_o,
  input logic                           err_o,
  input logic [3:0]                     cmd_id_o,
  input logic                           query_o,
  input logic [2:0]                     sub_o,
  input logic [VAL_W-1:0]               param_o,
  input logic                           param_err_o,
  input logic [$clog2(NUM_PORTS+1)-1:0] port_o
);
  a_r8_done_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r1_done_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_one_byte_per_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rx_valid_i & rx_ready_o) <= 1);

  a_r11_hold_between_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({cmd_id_o, sub_o, query_o, param_o, param_err_o, port_o}));

  a_r9_port_tag_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (port_o >= 1 && int'(port_o) <= NUM_PORTS));

  a_r4_sub_only_freq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((cmd_id_o == 4'd9) == (sub_o != 3'd0)));
endmodule

bind cmd_decoder cmd_decoder_chk #(.NUM_PORTS(NUM_PORTS), .VAL_W(VAL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .rx_ready_o (rx_ready_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .cmd_id_o   (cmd_id_o),
  .query_o    (query_o),
  .sub_o      (sub_o),
  .param_o    (param_o),
  .param_err_o(param_err_o),
  .port_o     (port_o)
);

// File: tb/cmd_decoder_test.sv
`timescale 1ns/1ps
module cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  vld = 2'b00;
  logic [7:0]  dat [2];
  logic [1:0]  rdy;
  logic        done, err, qry, perr;
  logic [3:0]  cid;
  logic [2:0]  sub;
  logic [31:0] prm;
  logic [1:0]  port;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(vld), .rx_data_i({dat[1], dat[0]}),
    .rx_ready_o(rdy), .done_o(done), .err_o(err), .cmd_id_o(cid), .query_o(qry),
    .sub_o(sub), .param_o(prm), .param_err_o(perr), .port_o(port)
  );

  // reference model state
  logic [7:0]  lq0[$];
  logic [7:0]  lq1[$];
  logic        e_done = 0, e_err = 0;
  logic [3:0]  h_cid = 0;
  logic [2:0]  h_sub = 0;
  logic        h_qry = 0, h_perr = 0;
  logic [31:0] h_prm = 0;
  logic [1:0]  h_port = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] up(logic [7:0] b);
    return (b >= "a" && b <= "z") ? b - 8'd32 : b;
  endfunction

  function automatic void model_line(logic [7:0] q[$], int p);
    int n = q.size();
    logic [7:0] a, b;
    logic [3:0] id = 0;
    logic [2:0] sc = 0;
    logic qf = 0, pe = 0;
    logic [31:0] v = 0;
    if (n < 2 || n > 16) begin e_err = 1; return; end
    a = up(q[0]); b = up(q[1]);
    if (a == "F") begin
      if (b == "R") sc = 1; else if (b == "T") sc = 2; else if (b == "S") sc = 3;
      else if (b == "U") sc = 4; else if (b == "D") sc = 5; else if (b == "?") sc = 6;
      id = (sc != 0) ? 4'd9 : 4'd0;
      qf = (b == "?");
    end else begin
      if      ({a, b} == "PD") id = 1;
      else if ({a, b} == "PW") id = 2;
      else if ({a, b} == "RC") id = 3;
      else if ({a, b} == "RR") id = 4;
      else if ({a, b} == "RS") id = 5;
      else if ({a, b} == "ST") id = 6;
      else if ({a, b} == "SQ") id = 7;
      else if ({a, b} == "VU") id = 8;
    end
    if (id == 0) begin e_err = 1; return; end
    for (int i = 2; i < n; i++) begin
      if (i == 2 && q[i] == 8'h3F) qf = 1;
      else if (q[i] >= "0" && q[i] <= "9") v = v * 32'd10 + 32'(q[i] - "0");
      else pe = 1;
    end
    e_done = 1; h_cid = id; h_sub = sc; h_qry = qf; h_prm = v; h_perr = pe;
    h_port = 2'(p + 1);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1", "done", 32'(done), 32'(e_done));
      chk("R8", "err", 32'(err), 32'(e_err));
      chk("R3", "cmd_id", 32'(cid), 32'(h_cid));
      chk("R4", "sub", 32'(sub), 32'(h_sub));
      chk("R5", "query", 32'(qry), 32'(h_qry));
      chk("R6", "param", prm, h_prm);
      chk("R7", "param_err", 32'(perr), 32'(h_perr));
      chk("R9", "port", 32'(port), 32'(h_port));
      // R10: lock and priority
      if (lq0.size() != 0) chk("R10", "ready1 while port0 open", 32'(rdy[1]), 0);
      else if (lq1.size() != 0) chk("R10", "ready0 while port1 open", 32'(rdy[0]), 0);
      else if (vld[0]) chk("R10", "ready1 behind port0", 32'(rdy[1]), 0);
      e_done = 0; e_err = 0;
      if (vld[0] && rdy[0]) begin
        if (dat[0] == 8'h0D) begin model_line(lq0, 0); lq0.delete(); end
        else lq0.push_back(dat[0]);
      end
      if (vld[1] && rdy[1]) begin
        if (dat[1] == 8'h0D) begin model_line(lq1, 1); lq1.delete(); end
        else lq1.push_back(dat[1]);
      end
    end
  end

  task automatic send_byte(int p, logic [7:0] b);
    bit got = 0;
    vld[p] = 1'b1;
    dat[p] = b;
    while (!got) begin
      @(negedge clk);
      if (rdy[p]) got = 1;
      @(posedge clk);
      #1;
    end
    vld[p] = 1'b0;
  endtask

  task automatic send_line(int p, string s);
    for (int i = 0; i < s.len(); i++) send_byte(p, s[i]);
    send_byte(p, 8'h0D);
  endtask

  task automatic gap();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    dat[0] = 0; dat[1] = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "reset done", 32'(done), 0);
    chk("R11", "reset err", 32'(err), 0);
    chk("R11", "reset cmd_id", 32'(cid), 0);
    chk("R11", "reset param", prm, 0);
    chk("R11", "reset port", 32'(port), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    gap();
    send_line(0, "PD");          gap();  // R3 plain code
    send_line(0, "pw");          gap();  // R2 folding
    send_line(0, "Rc");          gap();  // R2 mixed case
    send_line(0, "rr41");        gap();  // R6 digits
    send_line(0, "SQ?");         gap();  // R5 query
    send_line(0, "st?");         gap();  // R5 query lower
    send_line(0, "FR146520000"); gap();  // R4 rx
    send_line(0, "ft146520000"); gap();  // R4 tx
    send_line(0, "FS446000000"); gap();  // R4 simplex
    send_line(0, "fu005000");    gap();  // R4 up, six digits
    send_line(0, "FD005000");    gap();  // R4 down
    send_line(0, "F?");          gap();  // R4 R5 frequency query
    send_line(0, "VU12a");       gap();  // R7 non-digit
    send_line(0, "PD?5");        gap();  // R7 char after query
    send_line(0, "XX");          gap();  // R8 unknown
    send_line(0, "FZ1");         gap();  // R8 bad sub-letter
    send_line(0, "P");           gap();  // R8 short
    send_line(0, "");            gap();  // R8 empty
    send_line(0, "RS12345678901234");  gap();  // R8 16 chars accepted, R6 wrap
    send_line(0, "RS123456789012345"); gap();  // R8 17 chars discarded
    send_line(1, "RR41");        gap();  // R9 tag 2
    fork                                   // R10 priority to port 0
      send_line(0, "ST12");
      send_line(1, "rc7");
    join
    gap();
    fork                                   // R10 lock held by port 1
      send_line(1, "SQ9");
      begin @(posedge clk); #1; send_line(0, "pw1"); end
    join
    gap();
    send_line(1, "vu");          gap();  // R11 hold after err checked each clock
    finish_run();
  end
endmodule